// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register transfer request into a series of single-word memory accesses. A request carries a 16-bit register mask, a base address, a two-bit stepping mode, a direction bit (load or store), a base-update enable and a special-mode bit. The request is captured on a start strobe. The block then issues one access per selected register, lowest index first. Each access carries the register index and the word address, and each waits on a valid/ready handshake.

After the last access is accepted, the block raises a one-cycle completion pulse. Alongside it, the block reports the updated base value when base update was requested. It also reports whether the program counter (register 15) was reloaded and whether the status word must be restored from its saved copy. The register file, the memory and mode banking sit outside. This block only tells them what to do and when.

Top module: `xfer_seq_top`

## Requirements
- R1: The number of accepted accesses for a request equals the number of set bits in the captured 16-bit register mask.
- R2: Accesses are issued in ascending register index, each index being a set bit of the mask. `acc_load_o` repeats the captured direction (1 = load, 0 = store).
- R3: The first access address depends on `mode_i` as follows, where n is the transfer count and a word is 4 bytes:
  - 0 (ascending, after): base.
  - 1 (ascending, before): base+4.
  - 2 (descending, after): base-4n+4.
  - 3 (descending, before): base-4n.
- R4: Each access address is 4 higher than the previous accepted one. While valid is high and ready is low, index and address hold still.
- R5: `done_o` is high for exactly one cycle, in the cycle after the last access is accepted. With an empty mask it is high in the cycle after start, and no access is issued.
- R6: `wb_valid_o` is high with `done_o` only when the base-update enable was set. `wb_addr_o` is then base+4n for modes 0 and 1 and base-4n for modes 2 and 3.
- R7: `pc_load_o` is high with `done_o` exactly when the request was a load whose mask has bit 15 set.
- R8: `status_restore_o` is high with `done_o` exactly when a load with bit 15 set also had the special-mode bit. `acc_user_o` is high during accesses exactly when the special-mode bit was set and the request was not a load with bit 15 set.
- R9: A start strobe while the block is busy is ignored: the running sequence is unchanged and no second sequence follows.
- R10: While reset is asserted, no access is offered and no completion is reported; `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Captures a request when idle |
| reg_list_i | input | 16 | Register selection mask |
| base_i | input | 32 | Base address |
| mode_i | input | 2 | Stepping mode (see R3) |
| load_i | input | 1 | 1 = load, 0 = store |
| wb_en_i | input | 1 | Base update requested |
| spec_i | input | 1 | Special-mode bit |
| busy_o | output | 1 | A request is being processed |
| acc_valid_o | output | 1 | Access offered |
| acc_ready_i | input | 1 | Access accepted by memory side |
| acc_idx_o | output | 4 | Register index of the access |
| acc_addr_o | output | 32 | Word address of the access |
| acc_load_o | output | 1 | Direction of the access |
| acc_user_o | output | 1 | Access targets the user register bank |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Base update to be applied |
| wb_addr_o | output | 32 | New base value |
| pc_load_o | output | 1 | Program counter replaced by loaded word |
| status_restore_o | output | 1 | Status word restored from saved copy |

## Verification
The first access is offered in the cycle after the clock edge that captures start. Each later access appears in the cycle after the edge on which the previous one was accepted. `done_o` and its side-band results are due in the cycle after the final accepting edge, or in the cycle after start for an empty mask. The bench drives `start_i` and `acc_ready_i` at falling edges. It samples the outputs at the following falling edge and advances its expected-access pointer only when it drove ready high for the edge in between. Every comparison therefore lands exactly one register stage after the stimulus that caused it.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    MODE_ASC_AFTER  = 2'd0,
    MODE_ASC_BEFORE = 2'd1,
    MODE_DSC_AFTER  = 2'd2,
    MODE_DSC_BEFORE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  function automatic logic mode_ascending(input xfer_mode_e m);
    return (m == MODE_ASC_AFTER) || (m == MODE_ASC_BEFORE);
  endfunction

endpackage

// File: rtl/xfer_popcnt.sv
module xfer_popcnt #(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CNT_W'(vec_i[i]);
    end
  end

endmodule

// File: rtl/xfer_lowbit.sv
module xfer_lowbit #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [W-1:0]     onehot_o,
  output logic             any_o
);

  // Scan from the top so the lowest set bit is the last to win.
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o    = |vec_i;
  assign onehot_o = any_o ? (W'(1) << idx_o) : '0;

endmodule

// File: rtl/xfer_addr_plan.sv
module xfer_addr_plan
  import xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] new_base_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  xfer_mode_e        mode;

  assign mode = xfer_mode_e'(mode_i);
  assign span = ADDR_W'(cnt_i) * STEP;

  always_comb begin
    case (mode)
      MODE_ASC_AFTER:  first_addr_o = base_i;
      MODE_ASC_BEFORE: first_addr_o = base_i + STEP;
      MODE_DSC_AFTER:  first_addr_o = base_i - span + STEP;
      MODE_DSC_BEFORE: first_addr_o = base_i - span;
      default:         first_addr_o = base_i;
    endcase
  end

  assign new_base_o = mode_ascending(mode) ? (base_i + span) : (base_i - span);

endmodule

// File: rtl/xfer_seq_top.sv
module xfer_seq_top
  import xfer_pkg::*;
#(
  parameter int LIST_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(LIST_W),
  localparam int CNT_W     = $clog2(LIST_W + 1),
  localparam int PC_IDX    = LIST_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LIST_W-1:0] reg_list_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        mode_i,
  input  logic              load_i,
  input  logic              wb_en_i,
  input  logic              spec_i,
  output logic              busy_o,
  output logic              acc_valid_o,
  input  logic              acc_ready_i,
  output logic [IDX_W-1:0]  acc_idx_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              acc_load_o,
  output logic              acc_user_o,
  output logic              done_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic              pc_load_o,
  output logic              status_restore_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seq_state_e        state_q, state_d;
  logic [LIST_W-1:0] rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] nbase_q;
  logic              load_q, wben_q, user_q, pchit_q, rest_q;

  logic [CNT_W-1:0]  list_cnt;
  logic [ADDR_W-1:0] first_addr, new_base;
  logic [IDX_W-1:0]  cur_idx;
  logic [LIST_W-1:0] cur_onehot;
  logic              cur_any;

  logic cap_en, step_en, pc_in_list;

  xfer_popcnt #(.W(LIST_W), .CNT_W(CNT_W)) u_popcnt (
    .vec_i (reg_list_i),
    .cnt_o (list_cnt)
  );

  xfer_addr_plan #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_plan (
    .base_i       (base_i),
    .mode_i       (mode_i),
    .cnt_i        (list_cnt),
    .first_addr_o (first_addr),
    .new_base_o   (new_base)
  );

  xfer_lowbit #(.W(LIST_W), .IDX_W(IDX_W)) u_lowbit (
    .vec_i    (rem_q),
    .idx_o    (cur_idx),
    .onehot_o (cur_onehot),
    .any_o    (cur_any)
  );

  // Clock enables
  assign cap_en     = (state_q == ST_IDLE) && start_i;
  assign step_en    = (state_q == ST_RUN) && acc_ready_i && cur_any;
  assign pc_in_list = reg_list_i[PC_IDX];

  // Next-state logic
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          rem_d   = reg_list_i;
          addr_d  = first_addr;
          state_d = (reg_list_i == '0) ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        if (acc_ready_i) begin
          rem_d  = rem_q & ~cur_onehot;
          addr_d = addr_q + STEP;
          if (rem_d == '0) state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      nbase_q <= '0;
      load_q  <= 1'b0;
      wben_q  <= 1'b0;
      user_q  <= 1'b0;
      pchit_q <= 1'b0;
      rest_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_en || step_en) begin
        rem_q  <= rem_d;
        addr_q <= addr_d;
      end
      if (cap_en) begin
        nbase_q <= new_base;
        load_q  <= load_i;
        wben_q  <= wb_en_i;
        pchit_q <= load_i && pc_in_list;
        rest_q  <= load_i && pc_in_list && spec_i;
        user_q  <= spec_i && !(load_i && pc_in_list);
      end
    end
  end

  // Outputs
  assign busy_o           = (state_q != ST_IDLE);
  assign acc_valid_o      = (state_q == ST_RUN);
  assign acc_idx_o        = cur_idx;
  assign acc_addr_o       = addr_q;
  assign acc_load_o       = load_q;
  assign acc_user_o       = user_q;
  assign done_o           = (state_q == ST_DONE);
  assign wb_valid_o       = done_o && wben_q;
  assign wb_addr_o        = nbase_q;
  assign pc_load_o        = done_o && pchit_q;
  assign status_restore_o = done_o && rest_q;

endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              acc_valid_o,
  input logic              acc_ready_i,
  input logic [IDX_W-1:0]  acc_idx_o,
  input logic [ADDR_W-1:0] acc_addr_o,
  input logic              done_o,
  input logic              wb_valid_o,
  input logic              pc_load_o,
  input logic              status_restore_o
);

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_o && !acc_ready_i) |=> (acc_valid_o && $stable(acc_addr_o) && $stable(acc_idx_o))); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_o && acc_ready_i) |=> (!acc_valid_o || (acc_addr_o == $past(acc_addr_o) + ADDR_W'(WORD_BYTES)))); // R4

  AST_IDX_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_o && acc_ready_i) |=> (!acc_valid_o || (acc_idx_o > $past(acc_idx_o)))); // R2

  AST_ACCEPT_THEN_MORE_OR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_o && acc_ready_i) |=> (acc_valid_o || done_o)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o); // R6

  AST_PC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> done_o); // R7

  AST_RESTORE_NEEDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    status_restore_o |-> pc_load_o); // R8

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!acc_valid_o && !done_o)); // R9

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!acc_valid_o && !done_o && !busy_o); // R10
    end
  end

endmodule

bind xfer_seq_top xfer_seq_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .busy_o           (busy_o),
  .acc_valid_o      (acc_valid_o),
  .acc_ready_i      (acc_ready_i),
  .acc_idx_o        (acc_idx_o),
  .acc_addr_o       (acc_addr_o),
  .done_o           (done_o),
  .wb_valid_o       (wb_valid_o),
  .pc_load_o        (pc_load_o),
  .status_restore_o (status_restore_o)
);

// File: tb/tb_xfer_seq_top.sv
module tb_xfer_seq_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] reg_list_i;
  logic [31:0] base_i;
  logic [1:0]  mode_i;
  logic        load_i, wb_en_i, spec_i;
  logic        busy_o, acc_valid_o, acc_ready_i;
  logic [3:0]  acc_idx_o;
  logic [31:0] acc_addr_o;
  logic        acc_load_o, acc_user_o, done_o, wb_valid_o;
  logic [31:0] wb_addr_o;
  logic        pc_load_o, status_restore_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [3:0]  e_idx  [16];
  logic [31:0] e_addr [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  xfer_seq_top dut (
    .clk, .rst_n, .start_i, .reg_list_i, .base_i, .mode_i, .load_i, .wb_en_i,
    .spec_i, .busy_o, .acc_valid_o, .acc_ready_i, .acc_idx_o, .acc_addr_o,
    .acc_load_o, .acc_user_o, .done_o, .wb_valid_o, .wb_addr_o, .pc_load_o,
    .status_restore_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [1:0] m, input int n);
    case (m)
      2'd0:    return b;
      2'd1:    return b + 32'd4;
      2'd2:    return b - 32'(4 * n) + 32'd4;
      default: return b - 32'(4 * n);
    endcase
  endfunction

  function automatic logic [31:0] exp_wb(input logic [31:0] b, input logic [1:0] m, input int n);
    return (m < 2'd2) ? b + 32'(4 * n) : b - 32'(4 * n);
  endfunction

  task automatic run_op(input logic [15:0] lst, input logic [31:0] base, input logic [1:0] md,
                        input bit ld, input bit wb, input bit sp, input bit poke);
    int  n = 0;
    int  k = 0;
    bit  poked = 0;
    bit  rdy;
    logic [31:0] a0;
    bit  pc_hit;
    for (int i = 0; i < 16; i++) if (lst[i]) n++;
    a0 = exp_first(base, md, n);
    k  = 0;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        e_idx[k]  = 4'(i);
        e_addr[k] = a0 + 32'(4 * k);
        k++;
      end
    end
    k = 0;
    pc_hit = ld && lst[15];
    @(negedge clk);
    start_i = 1'b1; reg_list_i = lst; base_i = base; mode_i = md;
    load_i = ld; wb_en_i = wb; spec_i = sp;
    @(negedge clk);
    start_i = 1'b0;
    reg_list_i = 16'($urandom); base_i = $urandom; mode_i = 2'($urandom);
    forever begin
      if (k < n) begin
        chk(acc_valid_o == 1'b1, "R1", "valid", 32'(acc_valid_o), 32'd1);
        chk(acc_idx_o == e_idx[k], "R2", "index", 32'(acc_idx_o), 32'(e_idx[k]));
        chk(acc_load_o == ld, "R2", "direction", 32'(acc_load_o), 32'(ld));
        chk(acc_addr_o == e_addr[k], (k == 0) ? "R3" : "R4", "address", acc_addr_o, e_addr[k]);
        chk(done_o == 1'b0, "R5", "early done", 32'(done_o), 32'd0);
        chk(acc_user_o == (sp && !pc_hit), "R8", "user bank", 32'(acc_user_o), 32'(sp && !pc_hit));
        if (poke && !poked && k == n / 2) begin
          start_i = 1'b1; poked = 1;   // R9: strobe while busy
        end
        rdy = ($urandom % 4) != 0;
        acc_ready_i = rdy;
        @(negedge clk);
        start_i = 1'b0;
        acc_ready_i = 1'b0;
        if (rdy) k++;
      end else begin
        chk(done_o == 1'b1, "R5", "done", 32'(done_o), 32'd1);
        chk(acc_valid_o == 1'b0, "R1", "extra access", 32'(acc_valid_o), 32'd0);
        chk(wb_valid_o == wb, "R6", "wb valid", 32'(wb_valid_o), 32'(wb));
        if (wb) chk(wb_addr_o == exp_wb(base, md, n), "R6", "wb addr", wb_addr_o, exp_wb(base, md, n));
        chk(pc_load_o == pc_hit, "R7", "pc load", 32'(pc_load_o), 32'(pc_hit));
        chk(status_restore_o == (pc_hit && sp), "R8", "restore", 32'(status_restore_o), 32'(pc_hit && sp));
        @(negedge clk);
        chk(done_o == 1'b0, "R5", "done width", 32'(done_o), 32'd0);
        chk(busy_o == 1'b0, "R9", "no rerun", 32'(busy_o), 32'd0);
        break;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; acc_ready_i = 1'b0;
    reg_list_i = '0; base_i = '0; mode_i = '0; load_i = 0; wb_en_i = 0; spec_i = 0;
    repeat (3) @(negedge clk);
    chk(acc_valid_o == 1'b0, "R10", "reset valid", 32'(acc_valid_o), 32'd0);
    chk(done_o == 1'b0, "R10", "reset done", 32'(done_o), 32'd0);
    chk(busy_o == 1'b0, "R10", "reset busy", 32'(busy_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_op(16'h0000, 32'h0000_1000, 2'd3, 1, 1, 0, 0);  // R5 empty list
    for (int m = 0; m < 4; m++) begin
      run_op(16'hFFFF, 32'h2000_0040, 2'(m), 1, 1, 0, 1);  // R3 full list
      run_op(16'h0001, 32'h0000_0100, 2'(m), 0, 1, 0, 0);  // R3 single
    end
    run_op(16'h8000, 32'h0000_0800, 2'd0, 1, 1, 1, 0);  // R7 R8 restore
    run_op(16'h8001, 32'h0000_0800, 2'd1, 0, 0, 1, 0);  // R8 store user bank
    run_op(16'h4002, 32'h0000_0800, 2'd2, 1, 0, 1, 1);  // R8 load user bank
    run_op(16'h00F0, 32'h0000_0004, 2'd3, 0, 1, 0, 1);  // R6 wrap below zero

    // Random
    for (int t = 0; t < 60; t++) begin
      logic [15:0] l = 16'($urandom);
      if (t % 5 == 0) l = l & 16'($urandom);
      run_op(l, $urandom, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule